// File: doc/BRIEF.md
# Runtime-Reloadable Serial-Coefficient FIR Filter

This block is a direct-form FIR filter whose coefficient set can be replaced while the chip runs, through a single narrow host word. The host word holds a 16-bit signed coefficient in bits 15:0 and a load flag in bit 16. Each 0-to-1 transition of the flag becomes a one-cycle write pulse. On that pulse every tap register takes the coefficient of the tap before it, and the first tap takes the coefficient in the host word. A full set is loaded by sending it last-tap-first: the value sent first ends up in the last tap.

Each tap multiplies its coefficient by a delayed sample and adds the product to the running sum from the previous tap. It registers that sum, so the sum moves one tap per enabled clock. The samples in the delay line advance only on clocks that are not write cycles. The 31-bit sum is scaled by 2^-16 into a sign-extended 32-bit output word whose valid flag is always high. The coefficient of the last tap is brought out so the chain can be read back or cascaded.

Top module: `fir_reload_top`

## Requirements
- R1: A write pulse occurs only in the cycle after a clock edge where bit 16 of `host_word` is 1 and was 0 at the previous edge. Holding the flag high causes no further writes.
- R2: On each write, coefficients move one tap toward the end of the chain and tap 0 loads `host_word[15:0]`. After N writes, `tail_coef_o` holds the first coefficient written.
- R3: In a write cycle the sample enable is low, so `acc_o` keeps its value across that edge.
- R4: With stable coefficients c0 (first tap) to c(N-1), after the k-th enabled edge `acc_o` = sum over j of cj·x(k−(N−1)−j), wrapped to 31-bit two's complement. Here x(m) is the sample present at the m-th enabled edge. An impulse therefore shows the coefficients in tap order, starting N−1 enabled edges after it.
- R5: A synchronous reset clears all coefficients, the delay line, the sums and the flag history, so `acc_o`, `tail_coef_o` and `dac_word_o` read zero.
- R6: `dac_word_o[13:0]` equals `acc_o[29:16]`, and bits 31:14 all equal `acc_o[30]`.
- R7: `dac_valid_o` is always 1.
- R8: `tail_coef_o` changes only on a write or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_word | input | 17 | Bit 16 load flag, bits 15:0 signed coefficient |
| sample_in | input | 15 | Signed input sample |
| acc_o | output | 31 | Full-width filter sum from the last tap |
| dac_word_o | output | 32 | Scaled, sign-extended output word |
| dac_valid_o | output | 1 | Output valid, constant 1 |
| tail_coef_o | output | 16 | Coefficient held by the last tap |

## Verification
The assertions assume that reset is held from time zero for at least one edge. They also assume the load flag is a plain level that the host toggles between writes. The stimulus drives the flag low and then high for every coefficient, and holds it high for several cycles to probe for repeated writes. Outputs are compared against the reference model only once N enabled edges have passed since the last write. This keeps every sum inside the tap chain built from a single coefficient set, which is the condition under which the closed-form sum applies.

// File: rtl/fir_rl_pkg.sv
package fir_rl_pkg;
  localparam int DEF_TAPS   = 3;
  localparam int DEF_SMP_W  = 15;
  localparam int DEF_COEF_W = 16;
  localparam int DEF_ACC_W  = 31;
  localparam int DEF_WORD_W = 32;
  localparam int DEF_DAC_W  = 14;
  localparam int DEF_SHIFT  = 16;
endpackage

// File: rtl/fir_rl_loader.sv
module fir_rl_loader #(
  parameter int CW = fir_rl_pkg::DEF_COEF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW:0]   host_word,
  output logic [CW-1:0] coef_o,
  output logic          tap_wr_o,
  output logic          smp_ce_o
);
  localparam int FLAG_BIT = CW;

  logic flag_now;
  logic flag_last;

  assign flag_now = host_word[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) flag_last <= 1'b0;
    else     flag_last <= flag_now;
  end

  assign tap_wr_o = flag_now & ~flag_last;
  assign smp_ce_o = ~tap_wr_o;
  assign coef_o   = host_word[CW-1:0];
endmodule

// File: rtl/fir_rl_taps.sv
module fir_rl_taps #(
  parameter int NT = fir_rl_pkg::DEF_TAPS,
  parameter int SW = fir_rl_pkg::DEF_SMP_W,
  parameter int CW = fir_rl_pkg::DEF_COEF_W,
  parameter int AW = fir_rl_pkg::DEF_ACC_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tap_wr,
  input  logic                 smp_ce,
  input  logic signed [CW-1:0] coef_in,
  input  logic signed [SW-1:0] sample_in,
  output logic signed [AW-1:0] acc_o,
  output logic signed [CW-1:0] tail_o
);
  localparam int PW = SW + CW;
  localparam int XW = (AW > PW) ? AW : PW;

  // multiply-accumulate, wrapped to the sum width
  function automatic logic signed [AW-1:0] mac(
    input logic signed [AW-1:0] s,
    input logic signed [CW-1:0] c,
    input logic signed [SW-1:0] x
  );
    logic signed [PW-1:0] p;
    logic signed [XW-1:0] t;
    p = PW'(c) * PW'(x);
    t = XW'(s) + XW'(p);
    return t[AW-1:0];
  endfunction

  logic signed [CW-1:0] coef_w [NT];
  logic signed [SW-1:0] tin_w  [NT];
  logic signed [AW-1:0] sum_w  [NT];

  for (genvar k = 0; k < NT; k++) begin : g_tap
    logic signed [CW-1:0] c_r;
    logic signed [AW-1:0] s_r;
    logic signed [CW-1:0] c_next;
    logic signed [AW-1:0] s_base;

    if (k == 0) begin : g_head
      assign c_next   = coef_in;
      assign s_base   = '0;
      assign tin_w[0] = sample_in;
    end else begin : g_body
      assign c_next = coef_w[k-1];
      assign s_base = sum_w[k-1];
    end

    always_ff @(posedge clk) begin
      if (rst)         c_r <= '0;
      else if (tap_wr) c_r <= c_next;
    end

    always_ff @(posedge clk) begin
      if (rst)         s_r <= '0;
      else if (smp_ce) s_r <= mac(s_base, c_r, tin_w[k]);
    end

    assign coef_w[k] = c_r;
    assign sum_w[k]  = s_r;

    // two sample registers per tap keep samples aligned with the sum pipeline
    if (k < NT - 1) begin : g_dly
      logic signed [SW-1:0] a_r;
      logic signed [SW-1:0] b_r;
      always_ff @(posedge clk) begin
        if (rst) begin
          a_r <= '0;
          b_r <= '0;
        end else if (smp_ce) begin
          a_r <= tin_w[k];
          b_r <= a_r;
        end
      end
      assign tin_w[k+1] = b_r;
    end
  end

  assign acc_o  = sum_w[NT-1];
  assign tail_o = coef_w[NT-1];
endmodule

// File: rtl/fir_rl_scaler.sv
module fir_rl_scaler #(
  parameter int WW = fir_rl_pkg::DEF_WORD_W,
  parameter int DW = fir_rl_pkg::DEF_DAC_W
) (
  input  logic          sign_i,
  input  logic [DW-1:0] mag_i,
  output logic [WW-1:0] word_o,
  output logic          valid_o
);
  localparam int EXT_W = WW - DW;

  assign word_o  = {{EXT_W{sign_i}}, mag_i};
  assign valid_o = 1'b1;
endmodule

// File: rtl/fir_reload_top.sv
module fir_reload_top #(
  parameter int NT = fir_rl_pkg::DEF_TAPS,
  parameter int SW = fir_rl_pkg::DEF_SMP_W,
  parameter int CW = fir_rl_pkg::DEF_COEF_W,
  parameter int AW = fir_rl_pkg::DEF_ACC_W,
  parameter int WW = fir_rl_pkg::DEF_WORD_W,
  parameter int DW = fir_rl_pkg::DEF_DAC_W,
  parameter int SH = fir_rl_pkg::DEF_SHIFT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW:0]   host_word,
  input  logic [SW-1:0] sample_in,
  output logic [AW-1:0] acc_o,
  output logic [WW-1:0] dac_word_o,
  output logic          dac_valid_o,
  output logic [CW-1:0] tail_coef_o
);
  localparam int MAG_HI = SH + DW - 1;

  // named internal events
  logic          tap_wr;
  logic          smp_ce;
  logic [CW-1:0] coef_bus;

  fir_rl_loader #(.CW(CW)) loader_i (
    .clk      (clk),
    .rst      (rst),
    .host_word(host_word),
    .coef_o   (coef_bus),
    .tap_wr_o (tap_wr),
    .smp_ce_o (smp_ce)
  );

  fir_rl_taps #(.NT(NT), .SW(SW), .CW(CW), .AW(AW)) taps_i (
    .clk      (clk),
    .rst      (rst),
    .tap_wr   (tap_wr),
    .smp_ce   (smp_ce),
    .coef_in  (coef_bus),
    .sample_in(sample_in),
    .acc_o    (acc_o),
    .tail_o   (tail_coef_o)
  );

  fir_rl_scaler #(.WW(WW), .DW(DW)) scaler_i (
    .sign_i (acc_o[AW-1]),
    .mag_i  (acc_o[MAG_HI:SH]),
    .word_o (dac_word_o),
    .valid_o(dac_valid_o)
  );
endmodule

// File: rtl/fir_reload_chk.sv
module fir_reload_chk #(
  parameter int CW = fir_rl_pkg::DEF_COEF_W,
  parameter int AW = fir_rl_pkg::DEF_ACC_W,
  parameter int WW = fir_rl_pkg::DEF_WORD_W,
  parameter int DW = fir_rl_pkg::DEF_DAC_W
) (
  input logic          clk,
  input logic          rst,
  input logic          flag,
  input logic          tap_wr,
  input logic [AW-1:0] acc,
  input logic [WW-1:0] dac_word,
  input logic          dac_valid,
  input logic [CW-1:0] tail
);
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    tap_wr |=> !tap_wr);

  assert_rise_writes_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> tap_wr);

  assert_held_flag_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (flag && $past(flag) && !$past(rst)) |-> !tap_wr);

  assert_sum_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    tap_wr |=> $stable(acc));

  assert_tail_still_R8: assert property (@(posedge clk) disable iff (rst)
    !tap_wr |=> $stable(tail));

  assert_reset_clears_R5: assert property (@(posedge clk)
    rst |=> (acc == '0 && tail == '0));

  assert_sign_ext_R6: assert property (@(posedge clk) disable iff (rst)
    dac_word[WW-1:DW] == {(WW-DW){acc[AW-1]}});

  assert_valid_high_R7: assert property (@(posedge clk) disable iff (rst)
    dac_valid);
endmodule

bind fir_reload_top fir_reload_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .flag     (host_word[16]),
  .tap_wr   (tap_wr),
  .acc      (acc_o),
  .dac_word (dac_word_o),
  .dac_valid(dac_valid_o),
  .tail     (tail_coef_o)
);

// File: tb/fir_reload_top_tb_top.sv
`timescale 1ns/1ps
module fir_reload_top_tb_top;
  localparam int NT = 3;
  localparam int SW = 15;
  localparam int CW = 16;
  localparam int AW = 31;
  localparam int WW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW:0]   host_word = '0;
  logic [SW-1:0] sample_in = '0;
  logic [AW-1:0] acc_o;
  logic [WW-1:0] dac_word_o;
  logic          dac_valid_o;
  logic [CW-1:0] tail_coef_o;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  longint mc   [NT];
  longint hist [2*NT];
  int     settle = 0;
  bit     prev_flag = 0;

  always #2 clk = ~clk;

  fir_reload_top dut_i (
    .clk(clk), .rst(rst), .host_word(host_word), .sample_in(sample_in),
    .acc_o(acc_o), .dac_word_o(dac_word_o), .dac_valid_o(dac_valid_o),
    .tail_coef_o(tail_coef_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint wrap_acc(input longint s);
    longint m;
    m = s & ((longint'(1) << AW) - 1);
    if (m >= (longint'(1) << (AW - 1))) m -= (longint'(1) << AW);
    return m;
  endfunction

  function automatic longint model_acc();
    longint s = 0;
    for (int k = 0; k < NT; k++) s += mc[k] * hist[NT-1+k];
    return wrap_acc(s);
  endfunction

  function automatic longint exp_dac(input longint a);
    int w;
    w = int'(a) >>> 16;
    return longint'(unsigned'(w));
  endfunction

  function automatic longint acc_s();
    return longint'($signed(acc_o));
  endfunction

  // one clock: drive at negedge, update model and check at next negedge
  task automatic step(input logic [SW-1:0] smp, input bit flg, input logic [CW-1:0] cw);
    longint pre_acc;
    bit wr;
    pre_acc = acc_s();
    host_word = {flg, cw};
    sample_in = smp;
    @(posedge clk);
    @(negedge clk);
    if (rst) begin
      for (int k = 0; k < NT; k++) mc[k] = 0;
      for (int k = 0; k < 2*NT; k++) hist[k] = 0;
      prev_flag = 0;
      settle = 0;
    end else begin
      wr = flg && !prev_flag;
      prev_flag = flg;
      if (wr) begin
        for (int k = NT-1; k > 0; k--) mc[k] = mc[k-1];
        mc[0] = longint'($signed(cw));
        settle = NT;
        chk("R3 sum held on write", acc_s(), pre_acc);
      end else begin
        for (int k = 2*NT-1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = longint'($signed(smp));
        if (settle > 0) settle--;
      end
    end
    chk("R8 tail coefficient", longint'($signed(tail_coef_o)), mc[NT-1]);
    chk("R6 output scaling", longint'(dac_word_o), exp_dac(acc_s()));
    chk("R7 valid", longint'(dac_valid_o), 1);
    if (settle == 0) chk("R4 filter sum", acc_s(), model_acc());
  endtask

  task automatic load(input logic [CW-1:0] h [NT]);
    for (int i = NT-1; i >= 0; i--) begin
      step(SW'($urandom), 1'b0, h[i]);
      step(SW'($urandom), 1'b1, h[i]);
    end
    chk("R2 reverse order tail", longint'($signed(tail_coef_o)), longint'($signed(h[NT-1])));
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] h [NT];
    logic [CW-1:0] held;
    longint amp;
    longint ex;
    void'($urandom(32'd4711));
    for (int k = 0; k < NT; k++) mc[k] = 0;
    for (int k = 0; k < 2*NT; k++) hist[k] = 0;

    @(negedge clk);
    rst = 1'b1;
    step('0, 1'b0, '0);
    step('0, 1'b0, '0);
    chk("R5 reset acc", acc_s(), 0);
    chk("R5 reset tail", longint'(tail_coef_o), 0);
    chk("R5 reset dac", longint'(dac_word_o), 0);
    rst = 1'b0;

    // directed set, impulse
    h[0] = 16'sd3; h[1] = -16'sd2; h[2] = 16'sd5;
    load(h);
    for (int i = 0; i < 2*NT; i++) step('0, 1'b0, '0);
    amp = 1000;
    for (int t = 0; t < 3*NT; t++) begin
      step((t == 0) ? SW'(amp) : '0, 1'b0, '0);
      ex = (t >= NT-1 && t <= 2*NT-2) ? amp * longint'($signed(h[t-NT+1])) : 0;
      chk("R4 impulse tap order", acc_s(), ex);
    end

    // step response
    for (int t = 0; t < 3*NT; t++) step(SW'(2000), 1'b0, '0);
    chk("R4 step response", acc_s(), 2000 * (3 - 2 + 5));

    // flag held high: no extra writes
    held = tail_coef_o;
    step(SW'(7), 1'b0, 16'h1111);
    step(SW'(7), 1'b1, 16'h1111);
    held = tail_coef_o;
    for (int i = 0; i < 5; i++) step(SW'($urandom), 1'b1, CW'($urandom));
    chk("R1 held flag no write", longint'(tail_coef_o), longint'(held));

    // large scale: full range coefficients, wrap corner
    h[0] = 16'h8000; h[1] = 16'h8000; h[2] = 16'h8000;
    load(h);
    for (int t = 0; t < 3*NT; t++) step(15'h4000, 1'b0, '0);
    chk("R4 wrap", acc_s(), wrap_acc(3 * 32768 * 16384));

    // random coefficients and samples
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < NT; k++) h[k] = CW'($urandom);
      load(h);
      for (int i = 0; i < 60; i++) step(SW'($urandom), 1'b0, CW'($urandom));
    end

    // reset mid-run
    rst = 1'b1;
    step(SW'(123), 1'b1, 16'h7777);
    rst = 1'b0;
    chk("R5 mid-run reset acc", acc_s(), 0);
    chk("R5 mid-run reset tail", longint'(tail_coef_o), 0);
    step(SW'(50), 1'b0, '0);
    chk("R5 coefficients cleared", acc_s(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule